// File: doc/BRIEF.md
# Instruction Fetch Sampling Unit

This block is a hardware profiling sampler for the instruction fetch stage. It counts fetch operations against a programmable limit, not decoded instructions. A plain sequential fetch block and a fetch started by a redirection (for example a taken branch) each count as one operation. The fetch whose start brings the count up to the limit is tagged, and the count then reloads to zero. The unit follows that tagged fetch through the pipeline and records its start address, which need not be an instruction boundary. It also records the number of cycles until the fetch completes, and a small set of event flags. When the sample is ready, the unit raises a one-cycle interrupt pulse.

While a sample is waiting for software, or while a tagged fetch is still in flight, the unit stops counting and tags nothing. Software re-arms the unit with a clear strobe. Several fetches may be outstanding at once, and they complete in the order they started. The unit keeps track of how many older fetches must complete before the tagged one. A fetch whose bytes are later thrown away by a late redirection still produces a sample, with a flag set to mark the discard.

Top module: `fetch_sample_unit`

## Requirements
- R1: While counting, every fetch-start strobe (`fs_valid`) that does not hit the limit raises `cur_count` by one, whether `fs_redirect` is 0 or 1. Fetch completions do not change it.
- R2: A counted fetch start for which `cur_count + 1 >= cfg_max_count` is the tagged fetch, and `cur_count` becomes 0 after that edge. A limit of 0 or 1 therefore tags every counted fetch.
- R3: `smp_addr` reports the full `fs_addr` of the tagged fetch start, unchanged, with no alignment applied.
- R4: `smp_latency` equals the number of clock edges from the edge that samples the tagged start to the edge that samples its completion. Completions arrive in start order, and up to `MAX_OUT` fetches may be outstanding.
- R5: The latency saturates at 2^LAT_W-1 and never wraps.
- R6: `smp_icmiss` is the `fc_icmiss` value given with the tagged fetch's completion. `smp_redirect` is the `fs_redirect` value given with its start.
- R7: `smp_discard` is the `fc_discard` value given with the tagged completion. The sample is still reported when that flag is 1.
- R8: After the edge that samples the tagged completion, `smp_valid` is 1 and `smp_irq` is 1 for exactly that one cycle.
- R9: While a tagged fetch is in flight or `smp_valid` is 1, `cur_count` holds its value and no fetch is tagged. A `sw_clear` given while `smp_valid` is 0 has no effect.
- R10: `sw_clear` while `smp_valid` is 1 drops `smp_valid` after the next edge and re-arms counting. The sample fields keep their values until the next sample.
- R11: After reset, `cur_count`, `smp_valid`, `smp_irq` and all sample fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_max_count | input | CNT_W | Sampling limit in fetch operations |
| fs_valid | input | 1 | Fetch operation starts this cycle |
| fs_addr | input | ADDR_W | Start address of the fetch operation |
| fs_redirect | input | 1 | Fetch was started by a redirection |
| fc_valid | input | 1 | Oldest outstanding fetch completes this cycle |
| fc_icmiss | input | 1 | Completing fetch missed the instruction cache |
| fc_discard | input | 1 | Completing fetch's bytes are thrown away |
| sw_clear | input | 1 | Software clear of the valid sample |
| cur_count | output | CNT_W | Current fetch count |
| smp_valid | output | 1 | A sample is held and unread |
| smp_addr | output | ADDR_W | Sampled fetch address |
| smp_latency | output | LAT_W | Sampled fetch latency in cycles |
| smp_icmiss | output | 1 | Sampled cache-miss flag |
| smp_redirect | output | 1 | Sampled redirect flag |
| smp_discard | output | 1 | Sampled discard flag |
| smp_irq | output | 1 | One-cycle sample-ready interrupt |

## Verification
Some properties are checked by assertions on every cycle. These are the count freezing while the unit is tracking or holding, the one-cycle interrupt that coincides with a valid sample, the sample fields holding between captures, the latency staying at its saturation value, and the number of older fetches still ahead of the tagged one staying below the in-flight occupancy. Other behaviour can only be shown by the bench scenarios running against the queue-based model. This covers which fetch gets tagged under different limits, the exact latency under pipelined in-order completion with a varying number of fetches in flight, the flags and addresses that end up in the sample, and the re-arming that follows a clear.

// File: rtl/fsu_pkg.sv
package fsu_pkg;
  typedef enum logic [1:0] {
    FSU_COUNT = 2'd0,
    FSU_TRACK = 2'd1,
    FSU_HOLD  = 2'd2
  } fsu_state_e;

  typedef struct packed {
    logic discard;
    logic redirect;
    logic icmiss;
  } fsu_flags_t;
endpackage

// File: rtl/fsu_interval.sv
module fsu_interval #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic [CNT_W-1:0] max_cnt,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign hit     = take && (cnt_inc >= {1'b0, max_cnt});

  always_comb begin
    cnt_d = cnt_q;
    if (hit) begin
      cnt_d = '0;
    end else if (take) begin
      cnt_d = cnt_inc[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_d;
    end
  end

  // R2: a tag decision always leaves the counter at the reload value
  a_r2_reload_zero: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt_q == '0));
endmodule

// File: rtl/fsu_flight.sv
module fsu_flight #(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_valid,
  input  logic fc_valid,
  input  logic tag,
  input  logic tracking,
  output logic tag_done
);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [OCC_W-1:0] occ_q, occ_d;
  logic [OCC_W-1:0] ahead_q, ahead_d;
  logic             ahead_en;
  logic             older_done;

  assign older_done = fc_valid && (occ_q != '0);
  assign tag_done   = tracking && fc_valid && (ahead_q == '0);

  always_comb begin
    occ_d = occ_q + OCC_W'(fs_valid) - OCC_W'(older_done);
  end

  always_comb begin
    ahead_en = 1'b0;
    ahead_d  = ahead_q;
    if (tag) begin
      ahead_en = 1'b1;
      ahead_d  = occ_q - OCC_W'(older_done);
    end else if (tracking && fc_valid && (ahead_q != '0)) begin
      ahead_en = 1'b1;
      ahead_d  = ahead_q - OCC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
    end else if (fs_valid || fc_valid) begin
      occ_q <= occ_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ahead_q <= '0;
    end else if (ahead_en) begin
      ahead_q <= ahead_d;
    end
  end

  // R4: in-flight occupancy stays within the supported depth
  a_r4_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OCC_W'(DEPTH));

  // R4: the tagged fetch is itself outstanding, so fewer fetches are ahead of it than in flight
  a_r4_ahead_below_occ: assert property (@(posedge clk) disable iff (!rst_n)
    tracking |-> (ahead_q < occ_q));
endmodule

// File: rtl/fsu_lat_timer.sv
module fsu_lat_timer #(
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  output logic [LAT_W-1:0] lat_q
);
  localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};
  localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);

  logic [LAT_W-1:0] lat_d;
  logic             lat_en;

  always_comb begin
    lat_en = 1'b0;
    lat_d  = lat_q;
    if (load) begin
      lat_en = 1'b1;
      lat_d  = LAT_ONE;
    end else if (run && (lat_q != LAT_MAX)) begin
      lat_en = 1'b1;
      lat_d  = lat_q + LAT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (lat_en) begin
      lat_q <= lat_d;
    end
  end

  // R5: once at the ceiling the timer stays there until reloaded
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && (lat_q == LAT_MAX)) |=> (lat_q == LAT_MAX));
endmodule

// File: rtl/fsu_sample_bank.sv
module fsu_sample_bank
  import fsu_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int LAT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cap,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              start_redirect,
  input  logic              end_cap,
  input  logic [LAT_W-1:0]  end_lat,
  input  logic              end_icmiss,
  input  logic              end_discard,
  output logic [ADDR_W-1:0] smp_addr,
  output logic [LAT_W-1:0]  smp_lat,
  output fsu_flags_t        smp_flags
);
  logic [ADDR_W-1:0] pend_addr_q;
  logic              pend_redir_q;
  fsu_flags_t        flags_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_addr_q  <= '0;
      pend_redir_q <= 1'b0;
    end else if (start_cap) begin
      pend_addr_q  <= start_addr;
      pend_redir_q <= start_redirect;
    end
  end

  always_comb begin
    flags_d          = '0;
    flags_d.icmiss   = end_icmiss;
    flags_d.redirect = pend_redir_q;
    flags_d.discard  = end_discard;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_addr  <= '0;
      smp_lat   <= '0;
      smp_flags <= '0;
    end else if (end_cap) begin
      smp_addr  <= pend_addr_q;
      smp_lat   <= end_lat;
      smp_flags <= flags_d;
    end
  end

  // R10: visible sample fields change only on a capture
  a_r10_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !end_cap |=> ($stable(smp_addr) && $stable(smp_lat) && $stable(smp_flags)));
endmodule

// File: rtl/fetch_sample_unit.sv
module fetch_sample_unit
  import fsu_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int ADDR_W  = 48,
  parameter int LAT_W   = 16,
  parameter int MAX_OUT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_max_count,
  input  logic              fs_valid,
  input  logic [ADDR_W-1:0] fs_addr,
  input  logic              fs_redirect,
  input  logic              fc_valid,
  input  logic              fc_icmiss,
  input  logic              fc_discard,
  input  logic              sw_clear,
  output logic [CNT_W-1:0]  cur_count,
  output logic              smp_valid,
  output logic [ADDR_W-1:0] smp_addr,
  output logic [LAT_W-1:0]  smp_latency,
  output logic              smp_icmiss,
  output logic              smp_redirect,
  output logic              smp_discard,
  output logic              smp_irq
);
  fsu_state_e       state_q, state_d;
  logic             counting, tracking;
  logic             take, hit, tag_done;
  logic             irq_q;
  logic [LAT_W-1:0] lat_now;
  fsu_flags_t       flags;

  assign counting = (state_q == FSU_COUNT);
  assign tracking = (state_q == FSU_TRACK);
  assign take     = counting && fs_valid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FSU_COUNT: if (hit)      state_d = FSU_TRACK;
      FSU_TRACK: if (tag_done) state_d = FSU_HOLD;
      FSU_HOLD:  if (sw_clear) state_d = FSU_COUNT;
      default:                 state_d = FSU_COUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FSU_COUNT;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= tag_done;
    end
  end

  fsu_interval #(.CNT_W(CNT_W)) u_interval (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .max_cnt (cfg_max_count),
    .cnt_q   (cur_count),
    .hit     (hit)
  );

  fsu_flight #(.DEPTH(MAX_OUT)) u_flight (
    .clk      (clk),
    .rst_n    (rst_n),
    .fs_valid (fs_valid),
    .fc_valid (fc_valid),
    .tag      (hit),
    .tracking (tracking),
    .tag_done (tag_done)
  );

  fsu_lat_timer #(.LAT_W(LAT_W)) u_lat (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (hit),
    .run   (tracking),
    .lat_q (lat_now)
  );

  fsu_sample_bank #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_bank (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_cap      (hit),
    .start_addr     (fs_addr),
    .start_redirect (fs_redirect),
    .end_cap        (tag_done),
    .end_lat        (lat_now),
    .end_icmiss     (fc_icmiss),
    .end_discard    (fc_discard),
    .smp_addr       (smp_addr),
    .smp_lat        (smp_latency),
    .smp_flags      (flags)
  );

  assign smp_valid    = (state_q == FSU_HOLD);
  assign smp_irq      = irq_q;
  assign smp_icmiss   = flags.icmiss;
  assign smp_redirect = flags.redirect;
  assign smp_discard  = flags.discard;

  // R9: the fetch counter is frozen outside the counting state
  a_r9_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !counting |=> $stable(cur_count));

  // R8: the interrupt only appears together with a valid sample
  a_r8_irq_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    smp_irq |-> smp_valid);

  // R8: the interrupt is a single-cycle pulse
  a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    smp_irq |=> !smp_irq);

  // R7: a tagged completion always yields a valid sample, discarded or not
  a_r7_done_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    tag_done |=> smp_valid);

  // R10: a clear of a held sample drops the valid flag
  a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && sw_clear) |=> !smp_valid);
endmodule

// File: tb/fetch_sample_unit_tb.sv
`timescale 1ns/1ps
module fetch_sample_unit_tb;
  localparam int CNT_W  = 20;
  localparam int ADDR_W = 32;
  localparam int LAT_W  = 6;
  localparam int MAXO   = 4;
  localparam int LATMAX = (1 << LAT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CNT_W-1:0]  cfg_max_count = '0;
  logic              fs_valid = 1'b0;
  logic [ADDR_W-1:0] fs_addr = '0;
  logic              fs_redirect = 1'b0;
  logic              fc_valid = 1'b0;
  logic              fc_icmiss = 1'b0;
  logic              fc_discard = 1'b0;
  logic              sw_clear = 1'b0;
  logic [CNT_W-1:0]  cur_count;
  logic              smp_valid;
  logic [ADDR_W-1:0] smp_addr;
  logic [LAT_W-1:0]  smp_latency;
  logic              smp_icmiss, smp_redirect, smp_discard, smp_irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  fetch_sample_unit #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .LAT_W(LAT_W), .MAX_OUT(MAXO)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_max_count(cfg_max_count),
    .fs_valid(fs_valid), .fs_addr(fs_addr), .fs_redirect(fs_redirect),
    .fc_valid(fc_valid), .fc_icmiss(fc_icmiss), .fc_discard(fc_discard),
    .sw_clear(sw_clear), .cur_count(cur_count), .smp_valid(smp_valid),
    .smp_addr(smp_addr), .smp_latency(smp_latency), .smp_icmiss(smp_icmiss),
    .smp_redirect(smp_redirect), .smp_discard(smp_discard), .smp_irq(smp_irq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: queue of outstanding fetches in start order
  int          m_cyc, m_cnt, m_lat;
  bit          m_busy, m_valid, m_irq, m_ic, m_rd, m_dc;
  longint      m_addr;
  longint      q_addr[$];
  int          q_start[$];
  bit          q_rd[$];
  bit          q_tag[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc = 0; m_cnt = 0; m_lat = 0; m_busy = 0; m_valid = 0; m_irq = 0;
      m_ic = 0; m_rd = 0; m_dc = 0; m_addr = 0;
      q_addr.delete(); q_start.delete(); q_rd.delete(); q_tag.delete();
    end else begin
      bit frozen;
      frozen = m_busy || m_valid;
      m_irq  = 0;
      if (sw_clear && m_valid) m_valid = 0;
      if (fc_valid && q_tag.size() > 0) begin
        longint a; int s; bit r, t;
        a = q_addr.pop_front(); s = q_start.pop_front();
        r = q_rd.pop_front();   t = q_tag.pop_front();
        if (t) begin
          m_lat = m_cyc - s;
          if (m_lat > LATMAX) m_lat = LATMAX;
          m_addr = a; m_rd = r; m_ic = fc_icmiss; m_dc = fc_discard;
          m_valid = 1; m_irq = 1; m_busy = 0;
        end
      end
      if (fs_valid) begin
        bit t;
        t = 0;
        if (!frozen) begin
          if (m_cnt + 1 >= int'(cfg_max_count)) begin
            t = 1; m_cnt = 0; m_busy = 1;
          end else begin
            m_cnt++;
          end
        end
        q_addr.push_back(longint'(fs_addr)); q_start.push_back(m_cyc);
        q_rd.push_back(fs_redirect);         q_tag.push_back(t);
      end
      m_cyc++;
    end
  end

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(int'(cur_count) == m_cnt, "R1", "cur_count", cur_count, m_cnt);
      check(smp_valid == m_valid, "R9", "smp_valid", smp_valid, m_valid);
      check(smp_irq == m_irq, "R8", "smp_irq", smp_irq, m_irq);
      check(longint'(smp_addr) == m_addr, "R3", "smp_addr", smp_addr, m_addr);
      check(int'(smp_latency) == m_lat, "R4", "smp_latency", smp_latency, m_lat);
      check(smp_icmiss == m_ic && smp_redirect == m_rd, "R6", "flags", {smp_icmiss, smp_redirect}, {m_ic, m_rd});
      check(smp_discard == m_dc, "R7", "smp_discard", smp_discard, m_dc);
    end
  end

  task automatic idle_inputs();
    fs_valid = 0; fs_redirect = 0; fc_valid = 0; fc_icmiss = 0; fc_discard = 0; sw_clear = 0;
  endtask

  // One isolated fetch: start, then completion after lat edges
  task automatic one_fetch(input logic [ADDR_W-1:0] a, input bit rd, input int lat,
                           input bit ic, input bit dc);
    fs_valid = 1; fs_addr = a; fs_redirect = rd;
    @(negedge clk);
    idle_inputs();
    repeat (lat - 1) @(negedge clk);
    fc_valid = 1; fc_icmiss = ic; fc_discard = dc;
    @(negedge clk);
    idle_inputs();
  endtask

  // Pipelined traffic with in-order completion and automatic clearing
  task automatic stream(input int n, input int gmax, input int lmin, input int lmax,
                        input int cdelay);
    int started = 0, gap = 0, vage = 0, last_due = 0, t = 0, due;
    int dues[$];
    while (started < n || dues.size() > 0) begin
      idle_inputs();
      if (dues.size() > 0 && dues[0] == t) begin
        void'(dues.pop_front());
        fc_valid = 1; fc_icmiss = 1'($urandom_range(1, 0));
        fc_discard = ($urandom_range(3, 0) == 0);
      end
      if (started < n && dues.size() < MAXO && gap == 0) begin
        due = t + int'($urandom_range(lmax, lmin));
        if (due <= last_due) due = last_due + 1;
        dues.push_back(due); last_due = due;
        fs_valid = 1; fs_addr = $urandom; fs_redirect = 1'($urandom_range(1, 0));
        started++; gap = int'($urandom_range(gmax, 0));
      end else if (gap > 0) begin
        gap--;
      end
      if (smp_valid) begin
        vage++;
        if (vage >= cdelay) begin sw_clear = 1; vage = 0; end
      end else begin
        vage = 0;
      end
      @(negedge clk); t++;
    end
    idle_inputs();
  endtask

  initial begin
    logic [ADDR_W-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: reset state
    check(cur_count == 0 && smp_valid == 0 && smp_irq == 0, "R11", "reset ctl",
          {cur_count, smp_valid, smp_irq}, 0);
    check(smp_addr == 0 && smp_latency == 0 && smp_icmiss == 0 && smp_redirect == 0 && smp_discard == 0,
          "R11", "reset sample", smp_addr, 0);

    // R2/R3/R4/R8: limit 3, third fetch tagged at an unaligned address
    cfg_max_count = 3;
    one_fetch(32'h0000_1000, 0, 2, 0, 0);
    one_fetch(32'h0000_1020, 1, 2, 0, 0);
    check(cur_count == 2, "R1", "count after two fetches", cur_count, 2);
    one_fetch(32'h0000_1043, 0, 5, 1, 0);
    check(smp_valid == 1 && smp_irq == 1, "R8", "valid+irq", {smp_valid, smp_irq}, 3);
    check(smp_addr == 32'h0000_1043, "R3", "unaligned addr", smp_addr, 32'h1043);
    check(smp_latency == 5, "R4", "latency", smp_latency, 5);
    check(cur_count == 0, "R2", "reload", cur_count, 0);
    @(negedge clk);
    check(smp_irq == 0 && smp_valid == 1, "R8", "irq pulse width", smp_irq, 0);

    // R9: fetches while held are neither counted nor tagged
    held = smp_addr;
    one_fetch(32'h0000_2000, 0, 2, 0, 0);
    one_fetch(32'h0000_2020, 0, 2, 0, 0);
    one_fetch(32'h0000_2040, 0, 2, 0, 0);
    check(cur_count == 0 && smp_valid == 1, "R9", "frozen count", cur_count, 0);
    check(smp_addr == held, "R9", "sample untouched", smp_addr, held);

    // R10: clear re-arms, fields retained
    sw_clear = 1; @(negedge clk); sw_clear = 0;
    check(smp_valid == 0, "R10", "valid cleared", smp_valid, 0);
    check(smp_addr == held && smp_latency == 5, "R10", "fields retained", smp_addr, held);
    one_fetch(32'h0000_3000, 0, 2, 0, 0);
    check(cur_count == 1, "R10", "counting resumed", cur_count, 1);

    // R9: a clear without a valid sample changes nothing
    sw_clear = 1; @(negedge clk); sw_clear = 0;
    check(cur_count == 1 && smp_valid == 0 && smp_addr == held, "R9", "stray clear", cur_count, 1);

    // R5/R6/R7: limit 1, long latency saturates, all flags set
    cfg_max_count = 1;
    @(negedge clk);
    one_fetch(32'hDEAD_BEEF, 1, 80, 1, 1);
    check(smp_latency == LATMAX, "R5", "saturated latency", smp_latency, LATMAX);
    check(smp_icmiss && smp_redirect, "R6", "flags", {smp_icmiss, smp_redirect}, 3);
    check(smp_discard && smp_valid, "R7", "discarded still reported", {smp_discard, smp_valid}, 3);
    sw_clear = 1; @(negedge clk); sw_clear = 0;

    // R2: limit 0 tags every counted fetch
    cfg_max_count = 0;
    one_fetch(32'h0000_4004, 0, 3, 0, 0);
    check(smp_valid == 1 && smp_addr == 32'h4004, "R2", "limit zero", smp_addr, 32'h4004);
    sw_clear = 1; @(negedge clk); sw_clear = 0;

    // R1/R4: pipelined traffic against the reference model
    cfg_max_count = 4; stream(200, 2, 1, 6, 3);
    cfg_max_count = 2; stream(200, 0, 2, 9, 1);
    cfg_max_count = 7; stream(300, 3, 1, 4, 5);
    repeat (4) @(negedge clk);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule